// File: doc/BRIEF.md
# DMA Channel Transfer Counter with Completion Interrupt

This block is the per-channel completion logic of a DMA engine. Software programs a transfer size and writes the channel enable bit to 1. From then on the block counts the bus cycles that the channel completes. When the last programmed cycle finishes, it drops the enable and active status, raises a completion flag and, if interrupts are enabled, requests an interrupt from the CPU or from a data-transfer controller.

Software can resume the channel by writing the enable bit to 1 again. That write reloads the count and withdraws the pending completion. A size of zero means the largest count the counter can hold. A channel that is disabled in the middle of a bus cycle stays active until that cycle ends.

The controller is a five-state machine:
- `ST_IDLE`: disabled, with no completion pending.
- `ST_ARMED`: enabled and waiting for a bus cycle.
- `ST_BUSY`: enabled with a bus cycle in flight.
- `ST_DRAIN`: disabled by software while a bus cycle is still in flight.
- `ST_DONE`: the count has run out and the completion flag is set.

The transitions are:
- ENABLE: `ST_IDLE` or `ST_DONE` to `ST_ARMED`, loading the count.
- DISABLE: `ST_ARMED` to `ST_IDLE`.
- START: `ST_ARMED` to `ST_BUSY`.
- STEP: `ST_BUSY` to `ST_ARMED`, on a non-final cycle end.
- STEP_OFF: `ST_BUSY` to `ST_IDLE`, on a non-final cycle end together with a disable write.
- STOP_MID: `ST_BUSY` to `ST_DRAIN`, on a disable write.
- DRAINED: `ST_DRAIN` to `ST_IDLE`, on a non-final cycle end.
- FINISH: `ST_BUSY` or `ST_DRAIN` to `ST_DONE`, on the final cycle end.
- ACK: `ST_DONE` to `ST_IDLE`, on a flag clear.

Top module: `dma_tc_channel`

## Requirements
- R1: After reset, enable, active, flag and irq are 0 and the count is 0.
- R2: A write of 1 to the enable bit while the channel is neither enabled nor active loads `size_i` into the count and sets `en_o` on the next cycle.
- R3: Each `cyc_end_i` that arrives while `active_o` is 1 lowers the count by exactly 1. A `cyc_end_i` that arrives while `active_o` is 0 has no effect on the count or on any status output.
- R4: The cycle end that arrives with a count of 1 makes the following changes on the next cycle, all in that same cycle: `flag_o` becomes 1, `en_o` and `active_o` become 0, and the count becomes 0. The flag is never set before this.
- R5: A loaded size of 0 runs 2^CW transfers before the flag is set.
- R6: `irq_o` is 1 exactly while `flag_o` and `ie_i` are both 1. It follows `ie_i` without a clock delay.
- R7: A write of 1 to the enable bit while `flag_o` is 1 clears the flag and the irq on the next cycle, re-enables the channel and reloads the count.
- R8: `flag_clr_i` clears the flag on the next cycle. If it coincides with the final cycle end, the flag is set.
- R9: `cyc_start_i` while the channel is enabled and idle on the bus sets `active_o` on the next cycle. Every cycle end clears `active_o` on the next cycle.
- R10: A write of 0 to the enable bit clears `en_o` on the next cycle. If a bus cycle is in flight, `active_o` stays 1 until that cycle ends, and writes of 1 to the enable bit are ignored until then.
- R11: A write of 1 to the enable bit while `en_o` is already 1 does not reload the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_i | input | CW | Transfer size, loaded when the channel is enabled (0 means 2^CW) |
| en_we_i | input | 1 | Software write strobe for the enable bit |
| en_wd_i | input | 1 | Value written to the enable bit |
| ie_i | input | 1 | Completion interrupt enable |
| flag_clr_i | input | 1 | Software write of 0 to the completion flag |
| cyc_start_i | input | 1 | A bus cycle of this channel begins |
| cyc_end_i | input | 1 | A bus cycle of this channel ends |
| en_o | output | 1 | Enable bit |
| active_o | output | 1 | A bus cycle of this channel is in flight |
| flag_o | output | 1 | Transfer-complete flag |
| irq_o | output | 1 | Completion interrupt request |
| count_o | output | CW | Remaining transfer count |

## Verification
The bench runs the following patterns:
- A short size-3 transfer, which checks that the flag appears only on the final cycle end and not one end earlier.
- Stray cycle-end strobes while no bus cycle is in flight, which separate real decrements from ignored ones.
- A size of zero on an 8-bit counter, which checks for the full 256-transfer wrap and rules out an immediate finish.
- A clear coinciding with the final end, which checks the set-wins rule.
- A resume while the flag is set, which checks that the flag clears.
- Repeated enable writes while already enabled, which show that only a real 0-to-1 change reloads the count.
- A disable in the middle of a bus cycle, followed by an ignored re-enable, which separates the drain path from an immediate stop.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_BUSY  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } tc_state_t;

endpackage

// File: rtl/dma_tc_count.sv
module dma_tc_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          dec_i,
    input  logic [CW-1:0] size_i,
    output logic [CW-1:0] count_o,
    output logic          last_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    // A zero load wraps through the all-ones value on the first decrement,
    // so a size of zero runs the full 2^CW transfers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= size_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign count_o = cnt_q;
    assign last_o  = (cnt_q == ONE);

    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |=> (count_o == $past(count_o) - ONE)); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && !load_i) |=> $stable(count_o)); // R3

endmodule

// File: rtl/dma_tc_fsm.sv
module dma_tc_fsm
    import dma_tc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_we_i,
    input  logic en_wd_i,
    input  logic flag_clr_i,
    input  logic cyc_start_i,
    input  logic cyc_end_i,
    input  logic last_i,
    output logic load_o,
    output logic dec_o,
    output logic en_o,
    output logic active_o,
    output logic flag_o
);

    tc_state_t state_q, state_d;

    logic wr_on, wr_off;

    assign wr_on  = en_we_i &&  en_wd_i;
    assign wr_off = en_we_i && !en_wd_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_on) state_d = ST_ARMED;                  // ENABLE
            end
            ST_ARMED: begin
                if (wr_off)           state_d = ST_IDLE;        // DISABLE
                else if (cyc_start_i) state_d = ST_BUSY;        // START
            end
            ST_BUSY: begin
                if (cyc_end_i) begin
                    if (last_i)      state_d = ST_DONE;         // FINISH
                    else if (wr_off) state_d = ST_IDLE;         // STEP_OFF
                    else             state_d = ST_ARMED;        // STEP
                end else if (wr_off) begin
                    state_d = ST_DRAIN;                         // STOP_MID
                end
            end
            ST_DRAIN: begin
                if (cyc_end_i) begin
                    if (last_i) state_d = ST_DONE;              // FINISH
                    else        state_d = ST_IDLE;              // DRAINED
                end
            end
            ST_DONE: begin
                if (wr_on)           state_d = ST_ARMED;        // ENABLE (resume)
                else if (flag_clr_i) state_d = ST_IDLE;         // ACK
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load_o   = 1'b0;
        dec_o    = 1'b0;
        en_o     = 1'b0;
        active_o = 1'b0;
        flag_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = wr_on;
            end
            ST_ARMED: begin
                en_o = 1'b1;
            end
            ST_BUSY: begin
                en_o     = 1'b1;
                active_o = 1'b1;
                dec_o    = cyc_end_i;
            end
            ST_DRAIN: begin
                active_o = 1'b1;
                dec_o    = cyc_end_i;
            end
            ST_DONE: begin
                flag_o = 1'b1;
                load_o = wr_on;
            end
            default: ;
        endcase
    end

    AST_FLAG_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && cyc_end_i && last_i) |=> (flag_o && !en_o && !active_o)); // R4

    AST_ACTIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && cyc_end_i) |=> !active_o); // R9

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && wr_on) |=> (!flag_o && en_o)); // R7

    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !en_o && !cyc_end_i) |=> (active_o && !en_o)); // R10

endmodule

// File: rtl/dma_tc_channel.sv
module dma_tc_channel
    import dma_tc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] size_i,
    input  logic          en_we_i,
    input  logic          en_wd_i,
    input  logic          ie_i,
    input  logic          flag_clr_i,
    input  logic          cyc_start_i,
    input  logic          cyc_end_i,
    output logic          en_o,
    output logic          active_o,
    output logic          flag_o,
    output logic          irq_o,
    output logic [CW-1:0] count_o
);

    logic load, dec, last;

    dma_tc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we_i    (en_we_i),
        .en_wd_i    (en_wd_i),
        .flag_clr_i (flag_clr_i),
        .cyc_start_i(cyc_start_i),
        .cyc_end_i  (cyc_end_i),
        .last_i     (last),
        .load_o     (load),
        .dec_o      (dec),
        .en_o       (en_o),
        .active_o   (active_o),
        .flag_o     (flag_o)
    );

    dma_tc_count #(.CW(CW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .dec_i  (dec),
        .size_i (size_i),
        .count_o(count_o),
        .last_o (last)
    );

    assign irq_o = flag_o && ie_i;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> (count_o == $past(size_i))); // R2

    AST_FLAG_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> ($past(cyc_end_i) && count_o == '0)); // R4

    AST_NO_IRQ_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o |-> !irq_o); // R6

endmodule

// File: tb/tb_dma_tc_channel.sv
`timescale 1ns/1ps
module tb_dma_tc_channel;

    localparam int CW   = 8;
    localparam int MOD  = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] size_i = '0;
    logic          en_we_i = 1'b0, en_wd_i = 1'b0, ie_i = 1'b0, flag_clr_i = 1'b0;
    logic          cyc_start_i = 1'b0, cyc_end_i = 1'b0;
    logic          en_o, active_o, flag_o, irq_o;
    logic [CW-1:0] count_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt = 0;
    bit m_en = 0, m_act = 0, m_flg = 0;

    always #2.5 clk = ~clk;

    dma_tc_channel #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .size_i(size_i),
        .en_we_i(en_we_i), .en_wd_i(en_wd_i), .ie_i(ie_i), .flag_clr_i(flag_clr_i),
        .cyc_start_i(cyc_start_i), .cyc_end_i(cyc_end_i),
        .en_o(en_o), .active_o(active_o), .flag_o(flag_o), .irq_o(irq_o),
        .count_o(count_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int n_cnt = m_cnt;
        bit n_en = m_en, n_act = m_act, n_flg = m_flg;
        bit fin = m_act && cyc_end_i && (m_cnt == 1);
        if (flag_clr_i) n_flg = 0;
        if (m_act && cyc_end_i) begin
            n_cnt = (m_cnt + MOD - 1) % MOD;
            n_act = 0;
            if (fin) begin n_flg = 1; n_en = 0; end
        end
        if (en_we_i) begin
            if (en_wd_i && !m_en && !m_act) begin
                n_cnt = int'(size_i); n_en = 1; n_flg = 0;
            end else if (!en_wd_i && m_en) begin
                n_en = 0;
            end
        end
        if (cyc_start_i && m_en && !m_act && !(en_we_i && !en_wd_i)) n_act = 1;
        m_cnt = n_cnt; m_en = n_en; m_act = n_act; m_flg = n_flg;
    endtask

    task automatic compare();
        chk(int'(count_o) == m_cnt, "R3 count", int'(count_o), m_cnt);
        chk(en_o == m_en, "R2 en", int'(en_o), int'(m_en));
        chk(active_o == m_act, "R9 active", int'(active_o), int'(m_act));
        chk(flag_o == m_flg, "R4 flag", int'(flag_o), int'(m_flg));
        chk(irq_o == (m_flg && ie_i), "R6 irq", int'(irq_o), int'(m_flg && ie_i));
    endtask

    // one clock with the given inputs, then model update and comparison
    task automatic cyc(input bit we, input bit wd, input bit cs, input bit ce, input bit fc);
        en_we_i = we; en_wd_i = wd; cyc_start_i = cs; cyc_end_i = ce; flag_clr_i = fc;
        @(posedge clk);
        model_step();
        @(negedge clk);
        en_we_i = 0; en_wd_i = 0; cyc_start_i = 0; cyc_end_i = 0; flag_clr_i = 0;
        compare();
    endtask

    task automatic xfer();
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(en_o == 0 && active_o == 0 && flag_o == 0 && irq_o == 0, "R1 status", int'({en_o, active_o, flag_o, irq_o}), 0);
        chk(count_o == 0, "R1 count", int'(count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4: size 3 run
        ie_i = 1; size_i = 8'd3;
        cyc(1, 1, 0, 0, 0);
        chk(count_o == 3 && en_o, "R2 load", int'(count_o), 3);
        xfer(); xfer();
        chk(count_o == 1 && !flag_o, "R4 not early", int'(count_o), 1);
        cyc(0, 0, 0, 1, 0);   // stray end, no bus cycle
        chk(count_o == 1 && en_o && !active_o, "R3 stray end ignored", int'(count_o), 1);
        cyc(0, 0, 1, 0, 0);
        chk(active_o == 1, "R9 start", int'(active_o), 1);
        cyc(0, 0, 0, 1, 0);
        chk(flag_o && !en_o && !active_o && count_o == 0, "R4 final", int'(flag_o), 1);
        chk(irq_o == 1, "R6 irq on", int'(irq_o), 1);
        ie_i = 0; #1;
        chk(irq_o == 0, "R6 irq masked", int'(irq_o), 0);
        ie_i = 1; #1;

        // R7: resume clears flag
        size_i = 8'd2;
        cyc(1, 1, 0, 0, 0);
        chk(!flag_o && !irq_o && en_o && count_o == 2, "R7 resume", int'(flag_o), 0);

        // R11: enable while enabled does not reload
        size_i = 8'd9;
        cyc(1, 1, 0, 0, 0);
        chk(count_o == 2, "R11 no reload", int'(count_o), 2);
        xfer();
        cyc(1, 1, 0, 0, 0);
        chk(count_o == 1, "R11 no reload after step", int'(count_o), 1);

        // R8: set wins over clear
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1);
        chk(flag_o == 1, "R8 set wins", int'(flag_o), 1);
        cyc(0, 0, 0, 0, 1);
        chk(flag_o == 0 && irq_o == 0, "R8 clear", int'(flag_o), 0);

        // R10: disable while armed, then while a cycle is in flight
        size_i = 8'd5;
        cyc(1, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk(en_o == 0 && active_o == 0, "R10 disable armed", int'(en_o), 0);
        cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk(en_o == 0 && active_o == 1, "R10 drain", int'(active_o), 1);
        size_i = 8'd7;
        cyc(1, 1, 0, 0, 0);
        chk(en_o == 0 && count_o == 5, "R10 enable ignored in drain", int'(count_o), 5);
        cyc(0, 0, 0, 1, 0);
        chk(active_o == 0 && en_o == 0 && count_o == 4, "R10 drained", int'(count_o), 4);

        // R5: size zero runs 2^CW transfers
        size_i = 8'd0;
        cyc(1, 1, 0, 0, 0);
        for (int i = 0; i < MOD - 1; i++) xfer();
        chk(flag_o == 0 && count_o == 1, "R5 not done at 2^CW-1", int'(count_o), 1);
        xfer();
        chk(flag_o == 1 && count_o == 0, "R5 done at 2^CW", int'(flag_o), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule